// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and works out, from them, which of the three fault-confinement states the node is in. The frame logic around it detects the errors and completed frames. It reports each one to this block as a single-cycle strobe. The block answers with the counter values, a 2-bit state code and an error-passive flag. The frame logic reads that flag to choose between active and passive error flags.

The node must never leave bus-off on its own. Once the transmit counter passes its bus-off limit, the state is latched and every further strobe is ignored. Only a synchronous, active-high reset clears the latch and the counters. A strobe reporting 128 runs of 11 recessive bits is accepted at the port, but it starts no recovery. When several strobes land in one cycle, a fixed priority picks the single step each counter takes.

Top module: `can_fault_conf`

## Requirements
- R1: On a clock edge with `rst` high, both counters go to 0, `err_state` goes to 0 and `err_passive` goes to 0. These values are visible from the cycle after that edge.
- R2: The receive counter (8 bits) rises by 1 on `ev_rx_err`. It rises by 8 on `ev_rx_dom` (a dominant bit seen right after the node's own error flag) and falls by 1 on `ev_rx_ok`. It holds at 0 and at 255 rather than wrapping.
- R3: The transmit counter (9 bits) rises by 8 on `ev_tx_err` and falls by 1 on `ev_tx_ok`. It holds at 0 rather than going below it.
- R4: `err_state` is 0 (error active) while both counters are at or below 127. It is 1 (error passive) while either counter is above 127. It follows the counter values shown in the same cycle, so it also returns to 0 as soon as both counters are back at or below 127.
- R5: `err_passive` is 1 exactly when `err_state` is 1.
- R6: Each counter takes at most one step per cycle. For the receive counter, `ev_rx_dom` beats `ev_rx_err`, which beats `ev_rx_ok`. For the transmit counter, `ev_tx_err` beats `ev_tx_ok`.
- R7: When the transmit counter is above 255, `err_state` is 2 (bus-off), whatever the receive counter holds. Bus-off lasts until reset. While it lasts, neither counter changes on any strobe.
- R8: `ev_idle_seq` has no effect on either counter or on `err_state` in any state, bus-off included.
- R9: The receive and transmit counters update independently, so strobes to both in one cycle move both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_rx_err | input | 1 | Receive error strobe |
| ev_rx_dom | input | 1 | Dominant bit seen after own error flag, as receiver |
| ev_tx_err | input | 1 | Transmit error strobe |
| ev_rx_ok | input | 1 | Frame received without error |
| ev_tx_ok | input | 1 | Frame transmitted without error |
| ev_idle_seq | input | 1 | 128 runs of 11 recessive bits seen |
| err_state | output | 2 | 0 active, 1 passive, 2 bus-off |
| rx_err_cnt | output | 8 | Receive error counter |
| tx_err_cnt | output | 9 | Transmit error counter |
| err_passive | output | 1 | High while error passive |

## Verification
The bench builds the block with its default parameters. These are an 8-bit receive counter, a 9-bit transmit counter, a step of 8, a passive limit of 127 and a bus-off limit of 255. With these values, a few dozen strobes are enough to reach the 255 ceiling of the receive counter, cross the 127 limit in both directions and drive the transmit counter into bus-off. The scoreboard model predicts every cycle. It therefore covers the same-cycle priority cases, saturation at both ends, and the frozen counters after bus-off.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;

  // Add with a ceiling; values are carried in 32 bits
  function automatic int unsigned sat_up(int unsigned v, int unsigned step, int unsigned ceil);
    int unsigned s;
    s = v + step;
    return (s > ceil) ? ceil : s;
  endfunction

  // Subtract with a floor of zero
  function automatic int unsigned sat_down(int unsigned v, int unsigned step);
    return (v < step) ? 0 : v - step;
  endfunction

endpackage

// File: rtl/fc_counter.sv
module fc_counter #(
  parameter int W        = 8,
  parameter int BIG_STEP = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         up_big,
  input  logic         up_one,
  input  logic         down_one,
  output logic [W-1:0] cnt
);
  import fc_pkg::*;

  localparam int unsigned CEIL = (1 << W) - 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!hold) begin
      if (up_big)        cnt_d = W'(sat_up(32'(cnt_q), BIG_STEP, CEIL));
      else if (up_one)   cnt_d = W'(sat_up(32'(cnt_q), 1, CEIL));
      else if (down_one) cnt_d = W'(sat_down(32'(cnt_q), 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fc_state_map.sv
module fc_state_map #(
  parameter int REC_W         = 8,
  parameter int TEC_W         = 9,
  parameter int PASSIVE_ABOVE = 127,
  parameter int BUSOFF_ABOVE  = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REC_W-1:0] rec,
  input  logic [TEC_W-1:0] tec,
  output logic             busoff,
  output logic [1:0]       state,
  output logic             passive
);
  import fc_pkg::*;

  logic busoff_q;
  logic over_passive;
  fc_state_e st;

  assign busoff       = busoff_q || (32'(tec) > BUSOFF_ABOVE);
  assign over_passive = (32'(rec) > PASSIVE_ABOVE) || (32'(tec) > PASSIVE_ABOVE);

  // Terminal latch: only reset clears it
  always_ff @(posedge clk) begin
    if (rst) busoff_q <= 1'b0;
    else     busoff_q <= busoff;
  end

  always_comb begin
    if (busoff)            st = FC_BUSOFF;
    else if (over_passive) st = FC_PASSIVE;
    else                   st = FC_ACTIVE;
  end

  assign state   = st;
  assign passive = (st == FC_PASSIVE);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int REC_W         = 8,
  parameter int TEC_W         = 9,
  parameter int ERR_STEP      = 8,
  parameter int PASSIVE_ABOVE = 127,
  parameter int BUSOFF_ABOVE  = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_rx_err,
  input  logic             ev_rx_dom,
  input  logic             ev_tx_err,
  input  logic             ev_rx_ok,
  input  logic             ev_tx_ok,
  input  logic             ev_idle_seq,
  output logic [1:0]       err_state,
  output logic [REC_W-1:0] rx_err_cnt,
  output logic [TEC_W-1:0] tx_err_cnt,
  output logic             err_passive
);

  // Named internal events, brought out for the checker
  logic freeze;
  logic rx_step_big, rx_step_one, rx_step_down;
  logic tx_step_big, tx_step_down;

  assign rx_step_big  = ev_rx_dom;
  assign rx_step_one  = ev_rx_err;
  assign rx_step_down = ev_rx_ok;
  assign tx_step_big  = ev_tx_err;
  assign tx_step_down = ev_tx_ok;

  fc_counter #(.W(REC_W), .BIG_STEP(ERR_STEP)) u_rec (
    .clk(clk), .rst(rst), .hold(freeze),
    .up_big(rx_step_big), .up_one(rx_step_one), .down_one(rx_step_down),
    .cnt(rx_err_cnt)
  );

  fc_counter #(.W(TEC_W), .BIG_STEP(ERR_STEP)) u_tec (
    .clk(clk), .rst(rst), .hold(freeze),
    .up_big(tx_step_big), .up_one(1'b0), .down_one(tx_step_down),
    .cnt(tx_err_cnt)
  );

  fc_state_map #(
    .REC_W(REC_W), .TEC_W(TEC_W),
    .PASSIVE_ABOVE(PASSIVE_ABOVE), .BUSOFF_ABOVE(BUSOFF_ABOVE)
  ) u_map (
    .clk(clk), .rst(rst), .rec(rx_err_cnt), .tec(tx_err_cnt),
    .busoff(freeze), .state(err_state), .passive(err_passive)
  );

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int REC_W = 8,
  parameter int TEC_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_rx_err,
  input logic             ev_rx_dom,
  input logic             ev_tx_err,
  input logic             ev_rx_ok,
  input logic             ev_tx_ok,
  input logic             ev_idle_seq,
  input logic             freeze,
  input logic [1:0]       err_state,
  input logic [REC_W-1:0] rx_err_cnt,
  input logic [TEC_W-1:0] tx_err_cnt,
  input logic             err_passive
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (rx_err_cnt == '0 && tx_err_cnt == '0 && err_state == 2'd0)); // R1

  AST_RX_DOM_STEP: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_dom && !freeze && rx_err_cnt <= 8'd247) |=> rx_err_cnt == $past(rx_err_cnt) + 8'd8); // R6

  AST_TX_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_err && !freeze && tx_err_cnt <= 9'd503) |=> tx_err_cnt == $past(tx_err_cnt) + 9'd8); // R3

  AST_PASSIVE_FLAG: assert property (@(posedge clk) disable iff (rst)
    err_passive == (err_state == 2'd1)); // R5

  AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
    err_state != 2'd3); // R4

  AST_BUSOFF_ON_TEC: assert property (@(posedge clk) disable iff (rst)
    (tx_err_cnt > 9'd255) |-> err_state == 2'd2); // R7

  AST_BUSOFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_state == 2'd2) |=> (err_state == 2'd2 && $stable(rx_err_cnt) && $stable(tx_err_cnt))); // R7

  AST_IDLE_INERT: assert property (@(posedge clk) disable iff (rst)
    (ev_idle_seq && !ev_rx_err && !ev_rx_dom && !ev_rx_ok && !ev_tx_err && !ev_tx_ok)
    |=> ($stable(rx_err_cnt) && $stable(tx_err_cnt))); // R8

endmodule

bind can_fault_conf fc_checker #(.REC_W(REC_W), .TEC_W(TEC_W)) u_fc_chk (
  .clk(clk), .rst(rst),
  .ev_rx_err(ev_rx_err), .ev_rx_dom(ev_rx_dom), .ev_tx_err(ev_tx_err),
  .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok), .ev_idle_seq(ev_idle_seq),
  .freeze(freeze), .err_state(err_state), .rx_err_cnt(rx_err_cnt),
  .tx_err_cnt(tx_err_cnt), .err_passive(err_passive)
);

// File: tb/sim_can_fault_conf.sv
module sim_can_fault_conf;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_rx_err = 0, ev_rx_dom = 0, ev_tx_err = 0, ev_rx_ok = 0, ev_tx_ok = 0, ev_idle_seq = 0;
  logic [1:0] err_state;
  logic [7:0] rx_err_cnt;
  logic [8:0] tx_err_cnt;
  logic       err_passive;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_conf u0 (
    .clk(clk), .rst(rst), .ev_rx_err(ev_rx_err), .ev_rx_dom(ev_rx_dom),
    .ev_tx_err(ev_tx_err), .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok),
    .ev_idle_seq(ev_idle_seq), .err_state(err_state), .rx_err_cnt(rx_err_cnt),
    .tx_err_cnt(tx_err_cnt), .err_passive(err_passive)
  );

  typedef struct {
    int    rec;
    int    tec;
    int    st;
    int    pas;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  int m_rec = 0, m_tec = 0;
  bit m_off = 0;
  bit done = 0;

  function automatic exp_t predict(string tag);
    exp_t e;
    e.rec = m_rec;
    e.tec = m_tec;
    e.st  = m_off ? 2 : ((m_rec >= 128 || m_tec >= 128) ? 1 : 0);
    e.pas = (e.st == 1) ? 1 : 0;
    e.tag = tag;
    return e;
  endfunction

  // Driver: one cycle of strobes, model updated, expectation queued
  task automatic drive(input bit rxe, input bit dom, input bit txe,
                       input bit rxo, input bit txo, input bit idle, input string tag);
    @(negedge clk);
    rst = 0;
    ev_rx_err = rxe; ev_rx_dom = dom; ev_tx_err = txe;
    ev_rx_ok = rxo; ev_tx_ok = txo; ev_idle_seq = idle;
    if (!m_off) begin
      case (1'b1)
        dom:     m_rec = (m_rec + 8 > 255) ? 255 : m_rec + 8;
        rxe:     m_rec = (m_rec == 255) ? 255 : m_rec + 1;
        rxo:     m_rec = (m_rec == 0) ? 0 : m_rec - 1;
        default: ;
      endcase
      if (txe)      m_tec = m_tec + 8;
      else if (txo) m_tec = (m_tec == 0) ? 0 : m_tec - 1;
      if (m_tec >= 256) m_off = 1;
    end
    q.push_back(predict(tag));
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1;
    {ev_rx_err, ev_rx_dom, ev_tx_err, ev_rx_ok, ev_tx_ok, ev_idle_seq} = '0;
    m_rec = 0; m_tec = 0; m_off = 0;
    q.push_back(predict(tag));
  endtask

  // Monitor: compares just after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (int'(rx_err_cnt) != e.rec || int'(tx_err_cnt) != e.tec ||
          int'(err_state) != e.st || int'(err_passive) != e.pas) begin
        n_fail++;
        $display("FAIL %s: got rec=%0d tec=%0d st=%0d pas=%0d, expected rec=%0d tec=%0d st=%0d pas=%0d",
                 e.tag, rx_err_cnt, tx_err_cnt, err_state, err_passive, e.rec, e.tec, e.st, e.pas);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state");
    // R2 single steps up and floor at zero
    for (int i = 0; i < 3; i++) drive(1,0,0,0,0,0, "R2 rx error +1");
    for (int i = 0; i < 4; i++) drive(0,0,0,1,0,0, "R2 rx ok -1 floor");
    // R6 priority on receive side
    drive(0,1,0,0,0,0, "R2 rx dominant +8");
    drive(1,1,0,1,0,0, "R6 rx priority");
    drive(1,0,0,1,0,0, "R6 rx err over ok");
    // R3 / R4 / R5 transmit counter to passive
    for (int i = 0; i < 16; i++) drive(0,0,1,0,0,0, "R4 tx climb to passive");
    drive(0,0,0,0,1,0, "R4 back to active at 127");
    drive(0,0,0,0,1,0, "R3 tx ok -1");
    drive(0,0,1,0,1,0, "R6 tx err over ok");
    drive(0,0,0,0,0,1, "R8 idle strobe inert");
    // R9 both counters in one cycle
    drive(1,0,0,0,1,0, "R9 independent counters");
    drive(0,0,1,1,0,0, "R9 independent counters");
    // R2 ceiling of receive counter, R5 passive flag via rec
    for (int i = 0; i < 32; i++) drive(0,1,0,0,0,0, "R2 rx climb to ceiling");
    drive(1,0,0,0,0,0, "R2 rx stays at 255");
    drive(0,0,0,0,0,1, "R8 idle in passive");
    // R7 bus-off
    for (int i = 0; i < 17; i++) drive(0,0,1,0,0,0, "R7 tx climb to bus-off");
    drive(0,0,0,1,1,0, "R7 frozen on ok strobes");
    drive(1,1,1,0,0,0, "R7 frozen on error strobes");
    for (int i = 0; i < 3; i++) drive(0,0,0,0,0,1, "R8 idle no recovery");
    do_reset("R1 reset leaves bus-off");
    drive(0,0,0,0,0,0, "R1 quiet after reset");
    drive(1,0,1,0,0,0, "R9 after reset");
    @(negedge clk);
    {ev_rx_err, ev_rx_dom, ev_tx_err, ev_rx_ok, ev_tx_ok, ev_idle_seq} = '0;
    @(posedge clk); #5;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule